// File: doc/BRIEF.md
# Counter Bit-Transition Event Stream

This block turns a free-running 64-bit count into a sparse stream of single-cycle events. It has two channels with the same logic. The kernel channel watches the virtual count and the hypervisor channel watches the physical count. In each channel, an 8-bit control word picks one of the sixteen low-order count bits and chooses whether a rising or a falling transition of that bit raises an event. The control word also carries an enable bit.

Each channel keeps the count sample from the previous cycle in a register. It compares that sample with the present count, so the count does not need to step by exactly one. An interrupt-mask input, shared by both channels, blocks event delivery while it is high. Detections that the mask blocks are lost, not held back. Each channel registers its control word on the next clock edge. The first comparison made under a new control word never produces an event, so changing the control word cannot cause a spurious event.

Top module: `evs_stream_pair`

## Requirements
- R1: While `rst_n` is low, both event outputs are 0.
- R2: When control bit 2 (enable) is 0, the channel never raises an event.
- R3: Control bits [7:4] hold an index n from 0 to 15, and the channel watches count bit n only. Changes on other bits produce no event.
- R4: If control bit 3 is 0, an event is raised when bit n was 1'b0 in the count presented in cycle t-1 and is 1'b1 in the count presented in cycle t. The event appears as a 1 on the event output during cycle t+1.
- R5: If control bit 3 is 1, an event is raised on the opposite transition: bit n goes from 1 in cycle t-1 to 0 in cycle t. The output timing is the same as in R4.
- R6: If `irq_mask_i` is high in detection cycle t, the event for that cycle is suppressed. It is not delivered later.
- R7: The kernel channel (`kern_ctl_i`, `kern_evt_o`) uses `virt_cnt_i`. The hypervisor channel (`hyp_ctl_i`, `hyp_evt_o`) uses `phys_cnt_i`. The two channels do not affect each other.
- R8: Each event lasts exactly one cycle. A count that holds steady after a transition does not raise the event again.
- R9: A control word presented in cycle t is first used for the comparison in cycle t+1. That first comparison never raises an event. The comparison in cycle t still uses the previous control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| virt_cnt_i | input | 64 | Virtual count, watched by the kernel channel |
| phys_cnt_i | input | 64 | Physical count, watched by the hypervisor channel |
| kern_ctl_i | input | 8 | Kernel control word: [2] enable, [3] falling select, [7:4] bit index |
| hyp_ctl_i | input | 8 | Hypervisor control word, same field layout |
| irq_mask_i | input | 1 | Interrupt mask; high blocks event delivery on both channels |
| kern_evt_o | output | 1 | Kernel event pulse |
| hyp_evt_o | output | 1 | Hypervisor event pulse |

## Verification
The bench builds the block with its default parameters: a 64-bit count and a 4-bit index, which give an 8-bit control word. With these values every one of the sixteen watched bit positions can be reached. The bench does this by loading counts directly next to a carry into bit 15 rather than counting up to it, and random count jumps exercise the non-unit steps that the registered previous sample must handle.

// File: rtl/evs_pkg.sv
package evs_pkg;
  // Control word field positions; these positions are decoded by software.
  localparam int unsigned CTL_EN_BIT  = 2;
  localparam int unsigned CTL_POL_BIT = 3;
  localparam int unsigned CTL_SEL_LSB = 4;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/evs_rst_sync.sv
module evs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/evs_bit_pick.sv
module evs_bit_pick import evs_pkg::*; #(
  parameter int unsigned SEL_W = 4,
  localparam int unsigned NB   = 1 << SEL_W
) (
  input  logic [NB-1:0]    prev_i,
  input  logic [NB-1:0]    curr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  edge_kind_e       kind_i,
  output logic             hit_o
);
  logic [NB-1:0] rise_v;
  logic [NB-1:0] fall_v;

  // One transition detector per watchable bit position.
  for (genvar i = 0; i < NB; i++) begin : g_bit
    assign rise_v[i] = ~prev_i[i] &  curr_i[i];
    assign fall_v[i] =  prev_i[i] & ~curr_i[i];
  end

  always_comb begin
    if (kind_i == EDGE_FALL) begin
      hit_o = fall_v[sel_i];
    end else begin
      hit_o = rise_v[sel_i];
    end
  end
endmodule

// File: rtl/evs_channel.sv
module evs_channel import evs_pkg::*; #(
  parameter int unsigned SEL_W = 4,
  localparam int unsigned NB    = 1 << SEL_W,
  localparam int unsigned CTL_W = CTL_SEL_LSB + SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB-1:0]    cnt_i,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             mask_i,
  output logic             evt_o
);
  // state
  logic [NB-1:0]    prev_q, prev_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             vld_q, vld_d;
  logic             fresh_q, fresh_d;
  logic             evt_q, evt_d;

  // decode of the active control word
  logic             ctl_en;
  edge_kind_e       ctl_kind;
  logic [SEL_W-1:0] ctl_sel;
  logic             ctl_ce;
  logic             edge_hit;
  logic             unused_ctl;

  assign ctl_en     = ctl_q[CTL_EN_BIT];
  assign ctl_kind   = edge_kind_e'(ctl_q[CTL_POL_BIT]);
  assign ctl_sel    = ctl_q[CTL_SEL_LSB +: SEL_W];
  assign unused_ctl = ^ctl_q[1:0];

  evs_bit_pick #(
    .SEL_W (SEL_W)
  ) u_pick (
    .prev_i (prev_q),
    .curr_i (cnt_i),
    .sel_i  (ctl_sel),
    .kind_i (ctl_kind),
    .hit_o  (edge_hit)
  );

  // next state
  always_comb begin
    ctl_ce  = (ctl_i != ctl_q);
    ctl_d   = ctl_ce ? ctl_i : ctl_q;
    fresh_d = ctl_ce;
    prev_d  = cnt_i;
    vld_d   = 1'b1;
    evt_d   = vld_q & ctl_en & ~fresh_q & edge_hit & ~mask_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      vld_q   <= 1'b0;
      fresh_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      vld_q   <= vld_d;
      fresh_q <= fresh_d;
      evt_q   <= evt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_ce) begin
      ctl_q <= ctl_d;
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/evs_stream_pair.sv
module evs_stream_pair import evs_pkg::*; #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned NB    = 1 << SEL_W,
  localparam int unsigned CTL_W = CTL_SEL_LSB + SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] virt_cnt_i,
  input  logic [CNT_W-1:0] phys_cnt_i,
  input  logic [CTL_W-1:0] kern_ctl_i,
  input  logic [CTL_W-1:0] hyp_ctl_i,
  input  logic             irq_mask_i,
  output logic             kern_evt_o,
  output logic             hyp_evt_o
);
  localparam int unsigned NCH = 2;
  localparam int unsigned CH_KERN = 0;
  localparam int unsigned CH_HYP  = 1;

  logic             rst_int_n;
  logic [NB-1:0]    cnt_a [NCH];
  logic [CTL_W-1:0] ctl_a [NCH];
  logic [NCH-1:0]   evt_a;

  evs_rst_sync #(
    .STAGES (2)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Only the low NB bits can ever be selected.
  assign cnt_a[CH_KERN] = virt_cnt_i[NB-1:0];
  assign cnt_a[CH_HYP]  = phys_cnt_i[NB-1:0];
  assign ctl_a[CH_KERN] = kern_ctl_i;
  assign ctl_a[CH_HYP]  = hyp_ctl_i;

  if (CNT_W > NB) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^{virt_cnt_i[CNT_W-1:NB], phys_cnt_i[CNT_W-1:NB]};
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    evs_channel #(
      .SEL_W (SEL_W)
    ) u_ch (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .cnt_i  (cnt_a[c]),
      .ctl_i  (ctl_a[c]),
      .mask_i (irq_mask_i),
      .evt_o  (evt_a[c])
    );
  end

  assign kern_evt_o = evt_a[CH_KERN];
  assign hyp_evt_o  = evt_a[CH_HYP];
endmodule

// File: rtl/evs_stream_pair_chk.sv
module evs_stream_pair_chk import evs_pkg::*; #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned CTL_W = CTL_SEL_LSB + SEL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] virt_cnt_i,
  input logic [CNT_W-1:0] phys_cnt_i,
  input logic [CTL_W-1:0] kern_ctl_i,
  input logic [CTL_W-1:0] hyp_ctl_i,
  input logic             irq_mask_i,
  input logic             kern_evt_o,
  input logic             hyp_evt_o
);
  logic [CNT_W-1:0] vc_d1, vc_d2, pc_d1, pc_d2;
  logic [CTL_W-1:0] kc_d1, kc_d2, kc_d3, hc_d1, hc_d2, hc_d3;
  logic             mk_d1;
  logic [SEL_W-1:0] ks, hs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vc_d1 <= '0; vc_d2 <= '0; pc_d1 <= '0; pc_d2 <= '0;
      kc_d1 <= '0; kc_d2 <= '0; kc_d3 <= '0;
      hc_d1 <= '0; hc_d2 <= '0; hc_d3 <= '0;
      mk_d1 <= 1'b0;
    end else begin
      vc_d1 <= virt_cnt_i; vc_d2 <= vc_d1;
      pc_d1 <= phys_cnt_i; pc_d2 <= pc_d1;
      kc_d1 <= kern_ctl_i; kc_d2 <= kc_d1; kc_d3 <= kc_d2;
      hc_d1 <= hyp_ctl_i;  hc_d2 <= hc_d1; hc_d3 <= hc_d2;
      mk_d1 <= irq_mask_i;
    end
  end

  assign ks = kc_d2[CTL_SEL_LSB +: SEL_W];
  assign hs = hc_d2[CTL_SEL_LSB +: SEL_W];

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!kern_evt_o && !hyp_evt_o)
        else $error("R1 event during reset");
    end
  end

  p_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kern_evt_o || hyp_evt_o) |-> ((!kern_evt_o || kc_d2[CTL_EN_BIT]) &&
                                   (!hyp_evt_o  || hc_d2[CTL_EN_BIT])));

  p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kern_evt_o && !kc_d2[CTL_POL_BIT]) |-> (!vc_d2[ks] && vc_d1[ks]));

  p_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kern_evt_o && kc_d2[CTL_POL_BIT]) |-> (vc_d2[ks] && !vc_d1[ks]));

  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kern_evt_o || hyp_evt_o) |-> !mk_d1);

  p_hyp_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_evt_o |-> (pc_d2[hs] != pc_d1[hs]));

  p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kern_evt_o |=> !kern_evt_o);

  p_settle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kern_evt_o |-> (kc_d2 == kc_d3));
endmodule

bind evs_stream_pair evs_stream_pair_chk #(
  .CNT_W (CNT_W),
  .SEL_W (SEL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .virt_cnt_i (virt_cnt_i),
  .phys_cnt_i (phys_cnt_i),
  .kern_ctl_i (kern_ctl_i),
  .hyp_ctl_i  (hyp_ctl_i),
  .irq_mask_i (irq_mask_i),
  .kern_evt_o (kern_evt_o),
  .hyp_evt_o  (hyp_evt_o)
);

// File: tb/evs_stream_pair_tb.sv
module evs_stream_pair_tb;
  logic        clk;
  logic        rst_n;
  logic [63:0] virt_cnt_i, phys_cnt_i;
  logic [7:0]  kern_ctl_i, hyp_ctl_i;
  logic        irq_mask_i;
  logic        kern_evt_o, hyp_evt_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench model state, index 0 kernel, 1 hypervisor
  logic [63:0] m_prev [2];
  logic [7:0]  m_ctl  [2];
  logic        m_fresh[2];
  logic        pend_e [2];
  string       pend_tag;
  bit          have_pend = 0;
  logic [63:0] vc, pc;

  evs_stream_pair u_dut (
    .clk(clk), .rst_n(rst_n),
    .virt_cnt_i(virt_cnt_i), .phys_cnt_i(phys_cnt_i),
    .kern_ctl_i(kern_ctl_i), .hyp_ctl_i(hyp_ctl_i),
    .irq_mask_i(irq_mask_i),
    .kern_evt_o(kern_evt_o), .hyp_evt_o(hyp_evt_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Expected event from the requirements: enable bit2, falling bit3, index [7:4].
  function automatic logic exp_evt(input logic [63:0] prev, input logic [63:0] cur,
                                   input logic [7:0] ctl, input logic fresh, input logic m);
    logic [3:0] s;
    logic a, b, tr;
    s  = ctl[7:4];
    a  = prev[s];
    b  = cur[s];
    tr = ctl[3] ? (a & ~b) : (~a & b);
    return ctl[2] & ~fresh & tr & ~m;
  endfunction

  task automatic step(input logic [63:0] v, input logic [63:0] p,
                      input logic [7:0] kc, input logic [7:0] hc,
                      input logic m, input string tag);
    logic [63:0] cn [2];
    logic [7:0]  cc [2];
    @(negedge clk);
    if (have_pend) begin
      chk(pend_tag, "kern_evt_o", kern_evt_o, pend_e[0]);
      chk(pend_tag, "hyp_evt_o",  hyp_evt_o,  pend_e[1]);
    end
    virt_cnt_i = v; phys_cnt_i = p;
    kern_ctl_i = kc; hyp_ctl_i = hc;
    irq_mask_i = m;
    cn[0] = v; cn[1] = p; cc[0] = kc; cc[1] = hc;
    for (int c = 0; c < 2; c++) begin
      pend_e[c]  = exp_evt(m_prev[c], cn[c], m_ctl[c], m_fresh[c], m);
      m_fresh[c] = (cc[c] != m_ctl[c]);
      m_ctl[c]   = cc[c];
      m_prev[c]  = cn[c];
    end
    pend_tag  = tag;
    have_pend = 1;
  endtask

  task automatic run_inc(input int n, input logic [7:0] kc, input logic [7:0] hc,
                         input logic m, input string tag);
    for (int i = 0; i < n; i++) begin
      vc = vc + 64'd1;
      pc = pc + 64'd1;
      step(vc, pc, kc, hc, m, tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    virt_cnt_i = '0; phys_cnt_i = '0;
    kern_ctl_i = '0; hyp_ctl_i = '0; irq_mask_i = 1'b0;
    for (int c = 0; c < 2; c++) begin
      m_prev[c] = '0; m_ctl[c] = '0; m_fresh[c] = 1'b0;
    end
    vc = '0; pc = '0;

    // R1: reset state, with a changing count presented
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      virt_cnt_i = 64'(i); phys_cnt_i = 64'(i);
      chk("R1", "kern_evt_o", kern_evt_o, 1'b0);
      chk("R1", "hyp_evt_o",  hyp_evt_o,  1'b0);
    end
    @(negedge clk);
    virt_cnt_i = '0; phys_cnt_i = '0;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(64'd0, 64'd0, 8'h00, 8'h00, 1'b0, "R1");

    // R2: disabled, only index and polarity set
    run_inc(40, 8'h08, 8'h30, 1'b0, "R2");

    // R4: rising on bit 3
    run_inc(40, 8'h34, 8'h34, 1'b0, "R4");
    // R5: falling on bit 3
    run_inc(40, 8'h3C, 8'h3C, 1'b0, "R5");

    // R3: index 15 around the carry, and index 0
    vc = 64'h7FF0; pc = 64'hFFF0;
    run_inc(40, 8'hF4, 8'hFC, 1'b0, "R3");
    run_inc(12, 8'h04, 8'h0C, 1'b0, "R3");

    // R6: mask high blocks, then toggling mask
    run_inc(20, 8'h04, 8'h04, 1'b1, "R6");
    for (int i = 0; i < 16; i++) begin
      vc = vc + 64'd1; pc = pc + 64'd1;
      step(vc, pc, 8'h04, 8'h04, logic'(i[1]), "R6");
    end

    // R7: kernel count moves, physical count held
    for (int i = 0; i < 16; i++) begin
      vc = vc + 64'd1;
      step(vc, pc, 8'h04, 8'h04, 1'b0, "R7");
    end
    // R7: physical count moves, virtual count held
    for (int i = 0; i < 16; i++) begin
      pc = pc + 64'd1;
      step(vc, pc, 8'h54, 8'h54, 1'b0, "R7");
    end

    // R8: one transition of bit 5 then a held count
    vc = 64'h1E; pc = 64'h1E;
    for (int i = 0; i < 3; i++) step(vc, pc, 8'h54, 8'h54, 1'b0, "R8");
    step(64'h1F, 64'h1F, 8'h54, 8'h54, 1'b0, "R8");
    for (int i = 0; i < 8; i++) step(64'h20, 64'h20, 8'h54, 8'h54, 1'b0, "R8");
    vc = 64'h20; pc = 64'h20;

    // R9: control switches in cycles where the new setting would otherwise fire
    for (int i = 0; i < 24; i++) begin
      vc = vc + 64'd1; pc = pc + 64'd1;
      step(vc, pc, (i % 3 == 0) ? 8'h04 : 8'h0C, (i % 2 == 0) ? 8'h04 : 8'h0C, 1'b0, "R9");
    end

    // random mix of count steps, jumps, control changes and mask
    begin
      logic [7:0] kc, hc;
      kc = 8'h14; hc = 8'h2C;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(31, 0) == 0) kc = 8'($urandom);
        if ($urandom_range(31, 0) == 0) hc = 8'($urandom);
        if ($urandom_range(15, 0) == 0) vc = {$urandom, $urandom};
        else vc = vc + 64'($urandom_range(3, 0));
        if ($urandom_range(15, 0) == 0) pc = {$urandom, $urandom};
        else pc = pc + 64'($urandom_range(2, 0));
        step(vc, pc, kc, hc, ($urandom_range(3, 0) == 0), "R3");
      end
    end

    step(vc, pc, 8'h00, 8'h00, 1'b0, "R2");
    step(vc, pc, 8'h00, 8'h00, 1'b0, "R2");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule